// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block gathers interrupt requests from several kinds of source and hands the CPU one winner at a time. The sources are a reset request, a software trap strobe, one urgent edge-sensitive input, a number of external pin groups, and a number of peripheral status flags. Every request is first caught in its own pending latch. Among the latched requests that may be taken now, the arbiter first picks the highest programmable 2-bit software level. It then breaks any tie with a fixed hardware rank, which is the source index: a lower index wins.

The CPU supplies its current 2-bit level and an entry strobe. When the strobe is high and some request is eligible, the arbiter commits. In the next cycle it raises a one-cycle taken pulse, together with the winning source index and the level the CPU must adopt. Taking a reset, trap, urgent or external request clears its latch. Peripheral latches are only cleared by their own clear strobes. A separate wake output reports any pending request that should end a low-power halt.

Source index map (this is also the vector number and the hardware rank): 0 reset, 1 trap, 2 urgent input, 3 to 3+N_EXT-1 external groups, and then the peripherals. Maskable slot m, counting external groups first and then peripherals, belongs to source index 3+m. Its enable is bit m of `src_en_i` and its level is bits [2m+1:2m] of `src_prio_i`.

Top module: `irq_prio_arb`

## Requirements
- R1: Among eligible pending sources, a source with a higher software level always wins over one with a lower level, whatever their indices.
- R2: Among eligible sources that share the top level, the lowest source index wins. `vec_o` reports that index.
- R3: A maskable source is eligible only if its enable bit is 1 and its 2-bit level is strictly greater than `cur_lvl_i`.
- R4: Reset, trap and urgent sources are eligible at any `cur_lvl_i`, including 3, and arbitrate at level 3. Taking one of them gives `lvl_o` = 3. Reset and trap latch on every cycle their input is high.
- R5: When reset, trap and urgent requests are all pending together, they are taken in the order reset, then trap, then urgent.
- R6: The urgent input and each external group latch on a rising edge of their request line. The latch clears when that source is taken, or when the external group's clear strobe is high.
- R7: An external group's request line is the OR over the group's pins of (pin AND its select bit). A pin whose select bit is 0 has no effect.
- R8: A peripheral request line is its flag AND its enable, and it latches on a rising edge of that line. Being taken does not clear the latch. Its clear strobe does, and a pending request cleared this way is lost even while the flag stays high.
- R9: `wake_o` is 1 whenever any reset, trap, urgent or external latch is pending, regardless of `cur_lvl_i` and of the enable bits.
- R10: A latched maskable request that is not eligible stays pending. It is taken later, once it becomes eligible and wins.
- R11: If a latch is set and cleared in the same cycle, the set wins.
- R12: A commit happens only in a cycle where `enter_i` is 1 and some source is eligible. `take_o` is then 1 for the following cycle, with `vec_o` and `lvl_o` giving the winner's index and level. Synchronous reset clears every latch and `take_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_src_i | input | 1 | Reset source request |
| trap_i | input | 1 | Software trap strobe |
| urgent_i | input | 1 | Urgent edge-sensitive request input |
| ext_pin_i | input | N_EXT*PINS_PER_GRP | External pins, group g in bits [g*P +: P] |
| ext_sel_i | input | N_EXT*PINS_PER_GRP | Per-pin select bits |
| per_flag_i | input | N_PER | Peripheral status flags |
| src_en_i | input | N_EXT+N_PER | Enable per maskable slot |
| src_prio_i | input | 2*(N_EXT+N_PER) | 2-bit software level per maskable slot |
| cur_lvl_i | input | 2 | CPU's current level |
| enter_i | input | 1 | CPU ready to enter a service routine |
| clr_i | input | N_EXT+N_PER | Clear strobe per maskable slot |
| take_o | output | 1 | One-cycle interrupt-taken pulse |
| vec_o | output | $clog2(3+N_EXT+N_PER) | Winning source index |
| lvl_o | output | 2 | New current level for the CPU |
| wake_o | output | 1 | Wake-from-halt indication |

## Verification
Directed patterns set up pairs of sources that differ only in level, or only in index, to separate the software stage from the hardware tie-break. They also sweep the current level across a maskable source's own level, which exposes an off-by-one in the strict compare. Further cases check that a pin with its select bit clear has no effect, that a cleared peripheral request is lost while its flag is still high, that a same-cycle set and clear leaves the latch set, and that the fixed sources are taken at level 3 in their set order. Seeded random traffic then toggles every input at once against a bench model, which catches interactions between latching, clearing and arbitration that the directed cases leave out.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_TOP  = 2'd3;
    localparam int   IDX_RST  = 0;
    localparam int   IDX_TRAP = 1;
    localparam int   IDX_URG  = 2;
    localparam int   N_FIXED  = 3;

    // How a pending latch is set from its request line
    typedef enum logic {
        SET_LEVEL = 1'b0,
        SET_RISE  = 1'b1
    } set_mode_e;

    // Registered commit record presented to the CPU
    typedef struct packed {
        logic take;
        lvl_t lvl;
    } commit_t;

    function automatic logic lvl_passes(lvl_t src, lvl_t cur);
        return src > cur;
    endfunction

endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
    import irq_prio_pkg::*;
#(
    parameter set_mode_e MODE = SET_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);

    logic set;

    generate
        if (MODE == SET_RISE) begin : g_rise
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= req_i;
            end
            assign set = req_i & ~prev_q;
        end else begin : g_level
            assign set = req_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pend_o <= 1'b0;
        else     pend_o <= set | (pend_o & ~clr_i);
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> pend_o);

endmodule

// File: rtl/irq_two_stage_sel.sv
module irq_two_stage_sel
    import irq_prio_pkg::*;
#(
    parameter int NSRC = 9,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] elig_i,
    input  lvl_t [NSRC-1:0] lvl_i,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o,
    output lvl_t            top_o
);

    logic [3:0][NSRC-1:0] hit;
    logic [3:0]           has;
    logic [NSRC-1:0]      cand;

    // Stage 1: which software levels have an eligible source
    generate
        for (genvar l = 0; l < 4; l++) begin : g_lvl
            for (genvar i = 0; i < NSRC; i++) begin : g_src
                assign hit[l][i] = elig_i[i] && (lvl_i[i] == lvl_t'(l));
            end
            assign has[l] = |hit[l];
        end
    endgenerate

    always_comb begin
        if (has[3])      top_o = 2'd3;
        else if (has[2]) top_o = 2'd2;
        else if (has[1]) top_o = 2'd1;
        else             top_o = 2'd0;
    end

    assign any_o = |has;
    assign cand  = hit[top_o];

    // Stage 2: fixed rank, lowest index first
    always_comb begin
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) idx_o = IDXW'(i);
        end
    end

    always_comb begin
        if (any_o) begin
            // R1
            win_top_chk: assert (elig_i[idx_o] && (lvl_i[idx_o] == top_o));
        end
    end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int N_EXT        = 3,
    parameter int PINS_PER_GRP = 2,
    parameter int N_PER        = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 rst_src_i,
    input  logic                                 trap_i,
    input  logic                                 urgent_i,
    input  logic [N_EXT*PINS_PER_GRP-1:0]        ext_pin_i,
    input  logic [N_EXT*PINS_PER_GRP-1:0]        ext_sel_i,
    input  logic [N_PER-1:0]                     per_flag_i,
    input  logic [N_EXT+N_PER-1:0]               src_en_i,
    input  logic [2*(N_EXT+N_PER)-1:0]           src_prio_i,
    input  logic [1:0]                           cur_lvl_i,
    input  logic                                 enter_i,
    input  logic [N_EXT+N_PER-1:0]               clr_i,
    output logic                                 take_o,
    output logic [$clog2(3+N_EXT+N_PER)-1:0]     vec_o,
    output logic [1:0]                           lvl_o,
    output logic                                 wake_o
);

    localparam int N_MASK = N_EXT + N_PER;
    localparam int N_SRC  = N_FIXED + N_MASK;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int N_WAKE = N_FIXED + N_EXT;

    logic [N_SRC-1:0] req, pend, clr, elig;
    lvl_t [N_SRC-1:0] src_lvl;
    logic             any;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;
    logic             commit;
    commit_t          out_q;

    assign req[IDX_RST]  = rst_src_i;
    assign req[IDX_TRAP] = trap_i;
    assign req[IDX_URG]  = urgent_i;

    generate
        for (genvar g = 0; g < N_EXT; g++) begin : g_grp
            assign req[N_FIXED+g] = |(ext_pin_i[g*PINS_PER_GRP +: PINS_PER_GRP]
                                    & ext_sel_i[g*PINS_PER_GRP +: PINS_PER_GRP]);
        end
        for (genvar p = 0; p < N_PER; p++) begin : g_per
            assign req[N_FIXED+N_EXT+p] = per_flag_i[p] & src_en_i[N_EXT+p];
        end

        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            logic taken_now;
            assign taken_now = commit && (win_idx == IDX_W'(i));

            if (i < N_FIXED) begin : g_fixed
                assign clr[i]     = taken_now;
                assign elig[i]    = pend[i];
                assign src_lvl[i] = LVL_TOP;
            end else begin : g_mask
                if (i < N_WAKE) begin : g_ext_clr
                    assign clr[i] = taken_now | clr_i[i-N_FIXED];
                end else begin : g_per_clr
                    assign clr[i] = clr_i[i-N_FIXED];
                end
                assign src_lvl[i] = src_prio_i[2*(i-N_FIXED) +: 2];
                assign elig[i]    = pend[i] && src_en_i[i-N_FIXED]
                                    && lvl_passes(src_lvl[i], cur_lvl_i);
            end

            if (i < 2) begin : g_lvl_cell
                irq_pend_cell #(.MODE(SET_LEVEL)) u_cell (
                    .clk    (clk),
                    .rst    (rst),
                    .req_i  (req[i]),
                    .clr_i  (clr[i]),
                    .pend_o (pend[i])
                );
            end else begin : g_rise_cell
                irq_pend_cell #(.MODE(SET_RISE)) u_cell (
                    .clk    (clk),
                    .rst    (rst),
                    .req_i  (req[i]),
                    .clr_i  (clr[i]),
                    .pend_o (pend[i])
                );
            end
        end
    endgenerate

    irq_two_stage_sel #(.NSRC(N_SRC), .IDXW(IDX_W)) u_sel (
        .elig_i (elig),
        .lvl_i  (src_lvl),
        .any_o  (any),
        .idx_o  (win_idx),
        .top_o  (win_lvl)
    );

    assign commit = enter_i && any;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            vec_o <= '0;
        end else begin
            out_q.take <= commit;
            if (commit) begin
                out_q.lvl <= win_lvl;
                vec_o     <= win_idx;
            end
        end
    end

    assign take_o = out_q.take;
    assign lvl_o  = out_q.lvl;
    assign wake_o = |pend[N_WAKE-1:0];

    // R12
    take_needs_enter_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(enter_i));

    // R4
    fixed_top_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (take_o && (vec_o < IDX_W'(N_FIXED))) |-> (lvl_o == LVL_TOP));

    // R3
    mask_above_cur_chk: assert property (@(posedge clk) disable iff (rst)
        (take_o && (vec_o >= IDX_W'(N_FIXED))) |-> (lvl_o > $past(cur_lvl_i)));

    // R12
    vec_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (vec_o < IDX_W'(N_SRC)));

endmodule

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_EXT  = 3;
    localparam int PINS   = 2;
    localparam int N_PER  = 3;
    localparam int N_MASK = N_EXT + N_PER;
    localparam int N_SRC  = 3 + N_MASK;
    localparam int IDX_W  = $clog2(N_SRC);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_src, trap, urgent, enter;
    logic [N_EXT*PINS-1:0] pins, sel;
    logic [N_PER-1:0]      flag;
    logic [N_MASK-1:0]     en, clr;
    logic [2*N_MASK-1:0]   prio;
    logic [1:0]            cur;
    logic                  take_o, wake_o;
    logic [IDX_W-1:0]      vec_o;
    logic [1:0]            lvl_o;

    int checks = 0;
    int fails  = 0;
    logic [N_SRC-1:0] m_pend = '0;
    logic [N_SRC-1:0] m_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arb #(.N_EXT(N_EXT), .PINS_PER_GRP(PINS), .N_PER(N_PER)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rst_src_i  (rst_src),
        .trap_i     (trap),
        .urgent_i   (urgent),
        .ext_pin_i  (pins),
        .ext_sel_i  (sel),
        .per_flag_i (flag),
        .src_en_i   (en),
        .src_prio_i (prio),
        .cur_lvl_i  (cur),
        .enter_i    (enter),
        .clr_i      (clr),
        .take_o     (take_o),
        .vec_o      (vec_o),
        .lvl_o      (lvl_o),
        .wake_o     (wake_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: model from requirements, then compare at the ports
    task automatic step();
        logic [N_SRC-1:0] rq, setv, elig, clrv;
        logic [1:0] lv [N_SRC];
        logic any, commit;
        logic [1:0] best;
        int win;
        rq[0] = rst_src;
        rq[1] = trap;
        rq[2] = urgent;
        for (int g = 0; g < N_EXT; g++)
            rq[3+g] = |(pins[g*PINS +: PINS] & sel[g*PINS +: PINS]);
        for (int p = 0; p < N_PER; p++)
            rq[3+N_EXT+p] = flag[p] & en[N_EXT+p];
        for (int i = 0; i < N_SRC; i++)
            setv[i] = (i < 2) ? rq[i] : (rq[i] & ~m_prev[i]);
        for (int i = 0; i < N_SRC; i++) begin
            if (i < 3) begin
                lv[i] = 2'd3;
                elig[i] = m_pend[i];
            end else begin
                lv[i] = prio[2*(i-3) +: 2];
                elig[i] = m_pend[i] && en[i-3] && (lv[i] > cur);
            end
        end
        any = 1'b0; best = 2'd0; win = 0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!any || lv[i] > best)) begin
                any = 1'b1; best = lv[i]; win = i;
            end
        end
        commit = enter && any;
        for (int i = 0; i < N_SRC; i++)
            clrv[i] = (commit && win == i && i < 3 + N_EXT) || (i >= 3 && clr[i-3]);
        @(posedge clk);
        #1;
        m_pend = setv | (m_pend & ~clrv);
        m_prev = rq;
        chk(take_o == commit, "R12 take", int'(take_o), int'(commit));
        if (commit && take_o) begin
            chk(vec_o == IDX_W'(win), "R2 winner", int'(vec_o), win);
            chk(lvl_o == best, "R1 level", int'(lvl_o), int'(best));
        end
        chk(wake_o == |m_pend[3+N_EXT-1:0], "R9 wake", int'(wake_o), int'(|m_pend[3+N_EXT-1:0]));
    endtask

    task automatic expect_take(input int v, input int l, input string tag);
        chk(take_o == 1'b1, tag, int'(take_o), 1);
        chk(vec_o == IDX_W'(v), tag, int'(vec_o), v);
        chk(lvl_o == 2'(l), tag, int'(lvl_o), l);
    endtask

    task automatic expect_none(input string tag);
        chk(take_o == 1'b0, tag, int'(take_o), 0);
    endtask

    task automatic set_prio(input int m, input int l);
        prio[2*m +: 2] = 2'(l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_src = 0; trap = 0; urgent = 0; enter = 0;
        pins = '0; sel = '1; flag = '0; en = '1; clr = '0;
        prio = '0; cur = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R12 reset state
        chk(take_o == 1'b0, "R12 reset take", int'(take_o), 0);
        chk(wake_o == 1'b0, "R9 reset wake", int'(wake_o), 0);

        // R1: peripheral 0 at level 2 beats external 0 at level 1
        set_prio(0, 1); set_prio(3, 2);
        pins[0] = 1; flag[0] = 1;
        step(); expect_none("R12 no enter");
        enter = 1; step(); expect_take(6, 2, "R1 higher level wins");
        enter = 0; clr[3] = 1; step(); clr[3] = 0;
        enter = 1; step(); expect_take(3, 1, "R8 cleared peripheral lost");
        step(); expect_none("R6 auto clear");
        enter = 0; pins[0] = 0; flag[0] = 0; step();

        // R2: tie at level 2 between group 0 and group 1
        set_prio(0, 2); set_prio(1, 2);
        pins[0] = 1; pins[2] = 1; step();
        enter = 1; step(); expect_take(3, 2, "R2 tie lowest index");
        step(); expect_take(4, 2, "R2 tie second");
        step(); expect_none("R6 both cleared");
        enter = 0; pins = '0; step();

        // R3: strict compare against current level
        set_prio(2, 2); cur = 2'd2; pins[4] = 1; enter = 1;
        step(); expect_none("R3 equal level");
        step(); expect_none("R3 equal level held");
        chk(wake_o == 1'b1, "R9 wake independent of level", int'(wake_o), 1);
        cur = 2'd1; step(); expect_take(5, 2, "R10 taken once above");
        enter = 0; pins = '0; cur = 2'd0; step();

        // R4/R5: fixed sources at level 3, order reset, trap, urgent
        cur = 2'd3; trap = 1; step(); trap = 0;
        enter = 1; step(); expect_take(1, 3, "R4 trap at level 3");
        enter = 0; rst_src = 1; trap = 1; urgent = 1; step();
        rst_src = 0; trap = 0; enter = 1;
        step(); expect_take(0, 3, "R5 reset first");
        step(); expect_take(1, 3, "R5 trap second");
        step(); expect_take(2, 3, "R5 urgent third");
        step(); expect_none("R6 urgent cleared");
        urgent = 0; enter = 0; cur = 2'd0; step();

        // R7: unselected pin ignored, selected pins ORed
        set_prio(0, 1); sel[0] = 0; pins[0] = 1; step();
        chk(wake_o == 1'b0, "R7 unselected no wake", int'(wake_o), 0);
        enter = 1; step(); expect_none("R7 unselected ignored");
        enter = 0; sel[0] = 1; pins[1] = 1; step();
        enter = 1; step(); expect_take(3, 1, "R7 group OR");
        step(); expect_none("R7 one request per group");
        enter = 0; pins = '0; step();

        // R8: disabled peripheral forms no request
        set_prio(4, 2); en[4] = 0; flag[1] = 1; enter = 1; step(); step();
        expect_none("R8 flag without enable");
        enter = 0; flag[1] = 0; en[4] = 1; step();

        // R10: disabled external stays latched, taken when enabled
        set_prio(1, 1); en[1] = 0; pins[2] = 1; enter = 1; step(); step();
        expect_none("R10 disabled held");
        en[1] = 1; step(); expect_take(4, 1, "R10 taken after enable");
        enter = 0; pins = '0; step();

        // R11: set and clear in same cycle
        set_prio(5, 1); flag[2] = 1; clr[5] = 1; step(); clr[5] = 0;
        enter = 1; step(); expect_take(8, 1, "R11 set beats clear");
        enter = 0; clr[5] = 1; step(); clr[5] = 0; flag[2] = 0; step();

        // Random traffic against the model
        void'($urandom(32'h1234_5678));
        for (int n = 0; n < 3000; n++) begin
            rst_src = ($urandom % 64) == 0;
            trap    = ($urandom % 32) == 0;
            if (($urandom % 8) == 0) urgent = ~urgent;
            pins  = pins ^ (N_EXT*PINS)'($urandom % 64 & $urandom % 64);
            if (($urandom % 32) == 0) sel = (N_EXT*PINS)'($urandom);
            if (($urandom % 4) == 0) flag = flag ^ N_PER'($urandom);
            if (($urandom % 16) == 0) en = N_MASK'($urandom);
            if (($urandom % 16) == 0) prio = (2*N_MASK)'($urandom);
            if (($urandom % 4) == 0) cur = 2'($urandom);
            enter = ($urandom % 2) == 0;
            clr = N_MASK'($urandom % 64 & $urandom % 64 & $urandom % 64);
            step();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule